// File: doc/BRIEF.md
# Palette Color Lookup Table with Sequenced Byte Access

This block holds a 256-entry color table, with a 6-bit red, green and blue value in each entry. A processor loads and inspects the table through a narrow byte-wide register interface. A pixel pipeline uses the table to turn 8-bit pixel codes into 18-bit colors.

The processor never addresses the table directly. It first writes an entry number into the write-index register. It then writes three bytes to the data register, in the order red, green, blue. The first two components wait in a staging register. The third component commits the whole entry and moves the index on to the next entry, so a stream of triples fills consecutive entries. Reading follows the same pattern: a write to the read-index register starts a read sequence, and each data read returns the next component and advances the read index after blue.

On the pixel side, an 8-bit code arrives on a valid/ready stream and is ANDed with the pixel-mask register. The color of the selected entry is returned on a second valid/ready stream one clock later. The output stage holds its color stable while `col_ready` is low. The input is accepted only when the output stage is empty or is being drained in that same cycle (`pix_ready = !col_valid || col_ready`).

Top module: `pal_lut`

## Requirements
- R1: Reset sets every table entry to 0, the pixel mask to 0xFF, both indices to 0 and both component phases to red, and clears `col_valid`.
- R2: Register select codes on `io_sel` are: 0 = write index, 1 = read index, 2 = data, 3 = pixel mask. Writing code 0 loads the write index and returns the write phase to red. Successive data writes then supply red, green and blue, in that order.
- R3: After the blue component is written, the write index increments by one, so consecutive triples fill consecutive entries; the index wraps from 255 to 0.
- R4: Only bits [5:0] of a data write are stored; bits [7:6] are ignored, and data reads return 0 in bits [7:6].
- R5: An entry changes only when its blue component is written. Red and green wait in a staging register. A new write-index write discards a partial triple.
- R6: Writing code 1 loads the read index and returns the read phase to red. Each data read returns red, green, then blue of the current entry, then advances the read index, wrapping from 255 to 0.
- R7: A register read updates `io_rdata` at the clock edge that samples `io_rd`. Code 0 returns the write index, code 1 returns the read index, code 2 returns the next component and code 3 returns the pixel mask.
- R8: A pixel accepted on the input stream returns, one clock later, the entry selected by `pix_data & mask`, with red in `col_data[17:12]`, green in [11:6] and blue in [5:0].
- R9: While `col_valid` is high and `col_ready` is low, `col_data` and `col_valid` hold, and `pix_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_sel | input | 2 | Register select (0 write index, 1 read index, 2 data, 3 mask) |
| io_wr | input | 1 | Register write strobe |
| io_rd | input | 1 | Register read strobe |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read byte, registered |
| pix_valid | input | 1 | Pixel code valid |
| pix_ready | output | 1 | Pixel code accepted |
| pix_data | input | 8 | Pixel code |
| col_valid | output | 1 | Color valid |
| col_ready | input | 1 | Downstream ready for color |
| col_data | output | 18 | Color {red, green, blue} |

## Verification
Tables are loaded with distinct per-entry triples, so a swapped component or an off-by-one index shows up as a wrong value on readback. Bytes with the top bits set separate masking of the data from storing it. A lookup in the middle of a partial triple, and a restart that abandons one, separate commit-on-blue from committing each component as it arrives. Masked pixel codes and a stalled output stream show that the mask is applied before the table lookup, and that a held color is not overwritten while `col_ready` is low.

// File: rtl/pal_lut_pkg.sv
package pal_lut_pkg;
  typedef enum logic [1:0] {
    SEL_WIDX = 2'd0,
    SEL_RIDX = 2'd1,
    SEL_DATA = 2'd2,
    SEL_MASK = 2'd3
  } pal_sel_e;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } pal_phase_e;

  localparam int BUS_W = 8;
endpackage

// File: rtl/pal_wr_seq.sv
module pal_wr_seq
  import pal_lut_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 6,
  localparam int RGB_W = 3 * COMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_idx,
  input  logic [IDX_W-1:0]  idx_in,
  input  logic              data_we,
  input  logic [COMP_W-1:0] data_in,
  output logic              commit,
  output logic [IDX_W-1:0]  idx_q,
  output logic [RGB_W-1:0]  commit_rgb,
  output pal_phase_e        phase_q
);
  logic [COMP_W-1:0] stg_r, stg_g;

  assign commit     = data_we && !set_idx && (phase_q == PH_BLU);
  assign commit_rgb = {stg_r, stg_g, data_in};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= '0;
      phase_q <= PH_RED;
      stg_r   <= '0;
      stg_g   <= '0;
    end else if (set_idx) begin
      idx_q   <= idx_in;
      phase_q <= PH_RED;
    end else if (data_we) begin
      case (phase_q)
        PH_RED: begin stg_r <= data_in; phase_q <= PH_GRN; end
        PH_GRN: begin stg_g <= data_in; phase_q <= PH_BLU; end
        default: begin phase_q <= PH_RED; idx_q <= idx_q + 1'b1; end
      endcase
    end
  end
endmodule

// File: rtl/pal_rd_seq.sv
module pal_rd_seq
  import pal_lut_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 6,
  localparam int RGB_W = 3 * COMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_idx,
  input  logic [IDX_W-1:0]  idx_in,
  input  logic              data_re,
  input  logic [RGB_W-1:0]  entry_rgb,
  output logic [IDX_W-1:0]  idx_q,
  output logic [COMP_W-1:0] comp
);
  pal_phase_e phase_q;

  always_comb begin
    case (phase_q)
      PH_RED:  comp = entry_rgb[RGB_W-1 -: COMP_W];
      PH_GRN:  comp = entry_rgb[2*COMP_W-1 -: COMP_W];
      default: comp = entry_rgb[COMP_W-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= '0;
      phase_q <= PH_RED;
    end else if (set_idx) begin
      idx_q   <= idx_in;
      phase_q <= PH_RED;
    end else if (data_re) begin
      case (phase_q)
        PH_RED:  phase_q <= PH_GRN;
        PH_GRN:  phase_q <= PH_BLU;
        default: begin phase_q <= PH_RED; idx_q <= idx_q + 1'b1; end
      endcase
    end
  end
endmodule

// File: rtl/pal_store.sv
module pal_store #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 6,
  localparam int RGB_W = 3 * COMP_W,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [RGB_W-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [RGB_W-1:0] rdata,
  input  logic             pix_valid,
  output logic             pix_ready,
  input  logic [IDX_W-1:0] pix_idx,
  output logic             col_valid,
  input  logic             col_ready,
  output logic [RGB_W-1:0] col_data
);
  logic [RGB_W-1:0] mem [DEPTH];

  assign rdata     = mem[raddr];
  assign pix_ready = !col_valid || col_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_valid <= 1'b0;
      col_data  <= '0;
    end else if (pix_ready) begin
      col_valid <= pix_valid;
      if (pix_valid) col_data <= mem[pix_idx];
    end
  end
endmodule

// File: rtl/pal_lut.sv
module pal_lut
  import pal_lut_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 6,
  localparam int RGB_W = 3 * COMP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       io_sel,
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic [BUS_W-1:0] io_wdata,
  output logic [BUS_W-1:0] io_rdata,
  input  logic             pix_valid,
  output logic             pix_ready,
  input  logic [IDX_W-1:0] pix_data,
  output logic             col_valid,
  input  logic             col_ready,
  output logic [RGB_W-1:0] col_data
);
  logic [IDX_W-1:0]  mask_q;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  pal_phase_e        wr_phase;
  logic              commit;
  logic [RGB_W-1:0]  commit_rgb, rd_entry;
  logic [COMP_W-1:0] rd_comp;

  logic wr_widx, wr_ridx, wr_data, rd_data;
  assign wr_widx = io_wr && (io_sel == SEL_WIDX);
  assign wr_ridx = io_wr && (io_sel == SEL_RIDX);
  assign wr_data = io_wr && (io_sel == SEL_DATA);
  assign rd_data = io_rd && (io_sel == SEL_DATA);

  pal_wr_seq #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .set_idx(wr_widx), .idx_in(io_wdata[IDX_W-1:0]),
    .data_we(wr_data), .data_in(io_wdata[COMP_W-1:0]), .commit(commit),
    .idx_q(wr_idx), .commit_rgb(commit_rgb), .phase_q(wr_phase)
  );

  pal_rd_seq #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .set_idx(wr_ridx), .idx_in(io_wdata[IDX_W-1:0]),
    .data_re(rd_data), .entry_rgb(rd_entry), .idx_q(rd_idx), .comp(rd_comp)
  );

  pal_store #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(commit), .waddr(wr_idx), .wdata(commit_rgb),
    .raddr(rd_idx), .rdata(rd_entry), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_idx(pix_data & mask_q), .col_valid(col_valid), .col_ready(col_ready),
    .col_data(col_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '1;
    else if (io_wr && (io_sel == SEL_MASK)) mask_q <= io_wdata[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_rdata <= '0;
    end else if (io_rd) begin
      case (io_sel)
        SEL_WIDX: io_rdata <= BUS_W'(wr_idx);
        SEL_RIDX: io_rdata <= BUS_W'(rd_idx);
        SEL_DATA: io_rdata <= BUS_W'(rd_comp);
        default:  io_rdata <= BUS_W'(mask_q);
      endcase
    end
  end
endmodule

// File: rtl/pal_lut_chk.sv
module pal_lut_chk
  import pal_lut_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 6,
  localparam int RGB_W = 3 * COMP_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       io_sel,
  input logic             io_wr,
  input logic             io_rd,
  input logic [BUS_W-1:0] io_wdata,
  input logic [BUS_W-1:0] io_rdata,
  input logic             pix_valid,
  input logic             pix_ready,
  input logic             col_valid,
  input logic             col_ready,
  input logic [RGB_W-1:0] col_data,
  input logic [IDX_W-1:0] wr_idx,
  input pal_phase_e       wr_phase
);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_ready) |=> (col_valid && $stable(col_data)));

  // R9
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_ready) |-> !pix_ready);

  // R8
  one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready) |=> col_valid);

  // R4
  rd_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_sel == SEL_DATA) |=> (io_rdata[BUS_W-1:COMP_W] == '0));

  // R2
  widx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_sel == SEL_WIDX) |=> (wr_phase == PH_RED && wr_idx == $past(io_wdata[IDX_W-1:0])));

  // R3
  idx_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_sel == SEL_DATA && wr_phase == PH_BLU) |=> (wr_idx == $past(wr_idx) + 1'b1));

  // R5
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_sel == SEL_DATA && wr_phase != PH_BLU) |=> $stable(wr_idx));
endmodule

bind pal_lut pal_lut_chk #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_wr(io_wr), .io_rd(io_rd),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .pix_valid(pix_valid),
  .pix_ready(pix_ready), .col_valid(col_valid), .col_ready(col_ready),
  .col_data(col_data), .wr_idx(wr_idx), .wr_phase(wr_phase)
);

// File: tb/pal_lut_bench.sv
module pal_lut_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  io_sel = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        pix_valid = 1'b0, pix_ready;
  logic [7:0]  pix_data = '0;
  logic        col_valid, col_ready = 1'b1;
  logic [17:0] col_data;

  int vectors = 0, misses = 0;
  bit done = 1'b0;
  logic [17:0] exp_mem [256];

  always #10 clk = ~clk;

  pal_lut u_pal_lut (
    .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .pix_data(pix_data), .col_valid(col_valid),
    .col_ready(col_ready), .col_data(col_data)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] sel, logic [7:0] d);
    @(negedge clk);
    io_sel = sel; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic bus_rd(logic [1:0] sel, output logic [7:0] d);
    @(negedge clk);
    io_sel = sel; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  task automatic put_triple(int idx, logic [7:0] r, logic [7:0] g, logic [7:0] b);
    bus_wr(2'd2, r); bus_wr(2'd2, g); bus_wr(2'd2, b);
    exp_mem[idx[7:0]] = {r[5:0], g[5:0], b[5:0]};
  endtask

  task automatic lookup(logic [7:0] p, output logic [17:0] c);
    @(negedge clk);
    pix_data = p; pix_valid = 1'b1;
    @(negedge clk);
    pix_valid = 1'b0;
    c = col_data;
    chk("R8 valid", {31'd0, col_valid}, 32'd1);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    logic [17:0] c;
    chk("R1 col_valid", {31'd0, col_valid}, 32'd0);
    bus_rd(2'd3, d); chk("R1 mask", {24'd0, d}, 32'hFF);
    bus_rd(2'd0, d); chk("R1 widx", {24'd0, d}, 32'd0);
    bus_rd(2'd1, d); chk("R1 ridx", {24'd0, d}, 32'd0);
    lookup(8'd77, c); chk("R1 entry zero", {14'd0, c}, 32'd0);
  endtask

  task automatic t_fill();
    logic [7:0] d;
    logic [17:0] c;
    bus_wr(2'd0, 8'd5);
    for (int i = 5; i < 8; i++) put_triple(i, 8'(i), 8'(i + 16), 8'(i + 32));
    bus_rd(2'd0, d); chk("R3 widx after three", {24'd0, d}, 32'd8);
    bus_wr(2'd1, 8'd5);
    for (int i = 5; i < 8; i++) begin
      bus_rd(2'd2, d); chk("R6 red", {24'd0, d}, {26'd0, exp_mem[i][17:12]});
      bus_rd(2'd2, d); chk("R6 green", {24'd0, d}, {26'd0, exp_mem[i][11:6]});
      bus_rd(2'd2, d); chk("R6 blue", {24'd0, d}, {26'd0, exp_mem[i][5:0]});
    end
    bus_rd(2'd1, d); chk("R6 ridx advanced", {24'd0, d}, 32'd8);
    lookup(8'd6, c); chk("R2 order", {14'd0, c}, {14'd0, exp_mem[6]});
  endtask

  task automatic t_upper();
    logic [7:0] d;
    bus_wr(2'd0, 8'd20);
    put_triple(20, 8'hFF, 8'hC1, 8'h80);
    bus_wr(2'd1, 8'd20);
    bus_rd(2'd2, d); chk("R4 red masked", {24'd0, d}, 32'h3F);
    bus_rd(2'd2, d); chk("R4 green masked", {24'd0, d}, 32'h01);
    bus_rd(2'd2, d); chk("R4 blue masked", {24'd0, d}, 32'h00);
  endtask

  task automatic t_partial();
    logic [17:0] c;
    bus_wr(2'd0, 8'd9);
    bus_wr(2'd2, 8'h11); bus_wr(2'd2, 8'h22);
    lookup(8'd9, c); chk("R5 partial hidden", {14'd0, c}, 32'd0);
    bus_wr(2'd0, 8'd9);
    bus_wr(2'd2, 8'h05);
    lookup(8'd9, c); chk("R5 restart hidden", {14'd0, c}, 32'd0);
    bus_wr(2'd2, 8'h06); bus_wr(2'd2, 8'h07);
    exp_mem[9] = {6'h05, 6'h06, 6'h07};
    lookup(8'd9, c); chk("R5 committed", {14'd0, c}, {14'd0, exp_mem[9]});
  endtask

  task automatic t_wrap();
    logic [7:0] d;
    logic [17:0] c;
    bus_wr(2'd0, 8'd255);
    put_triple(255, 8'h2A, 8'h15, 8'h3F);
    put_triple(0, 8'h01, 8'h02, 8'h03);
    bus_rd(2'd0, d); chk("R3 wrap widx", {24'd0, d}, 32'd1);
    lookup(8'd0, c); chk("R3 wrap entry 0", {14'd0, c}, {14'd0, exp_mem[0]});
    bus_wr(2'd1, 8'd255);
    for (int k = 0; k < 3; k++) bus_rd(2'd2, d);
    bus_rd(2'd1, d); chk("R6 ridx wrap", {24'd0, d}, 32'd0);
    bus_rd(2'd2, d); chk("R6 wrap red", {24'd0, d}, 32'h01);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    logic [17:0] c;
    bus_wr(2'd3, 8'h0F);
    bus_rd(2'd3, d); chk("R7 mask readback", {24'd0, d}, 32'h0F);
    lookup(8'hF5, c); chk("R8 masked lookup", {14'd0, c}, {14'd0, exp_mem[5]});
    bus_wr(2'd3, 8'hFF);
    lookup(8'hFF, c); chk("R8 full mask", {14'd0, c}, {14'd0, exp_mem[255]});
  endtask

  task automatic t_stall();
    @(negedge clk);
    col_ready = 1'b0; pix_data = 8'd6; pix_valid = 1'b1;
    @(negedge clk);
    pix_data = 8'd7;
    chk("R9 first valid", {31'd0, col_valid}, 32'd1);
    chk("R9 first data", {14'd0, col_data}, {14'd0, exp_mem[6]});
    chk("R9 ready low", {31'd0, pix_ready}, 32'd0);
    @(negedge clk);
    chk("R9 held data", {14'd0, col_data}, {14'd0, exp_mem[6]});
    col_ready = 1'b1;
    @(negedge clk);
    pix_valid = 1'b0;
    chk("R9 second data", {14'd0, col_data}, {14'd0, exp_mem[7]});
    @(negedge clk);
    chk("R9 drained", {31'd0, col_valid}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) exp_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill();
    t_upper();
    t_partial();
    t_wrap();
    t_mask();
    t_stall();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vectors++; misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule